// File: doc/BRIEF.md
# Synchronous Character Receiver with Sync Hunt

This block receives a character-oriented synchronous serial stream. The receive clock `rxc` is a slow 1x bit clock. Each rising edge of `rxc` samples one bit of `rxd`, least significant bit first. A character carries 5 to 8 data bits and may be followed by an even or odd parity bit. Before it can deliver characters, the receiver has to find the character framing. It can do this internally, by sliding a window over the incoming bits until one programmed sync pattern matches, or a pair of them in a row. It can also do it externally: a high level on `sync_in` tells it where the framing starts.

The receiver runs on the system clock `clk`. `rxc`, `rxd` and `sync_in` are brought into that domain through a short synchronizer, and a rising edge of the synchronized `rxc` counts as one received bit. A three-state machine controls the receiver:

- **ST_HUNT** searches bit by bit.
- **ST_SECOND** checks the character that follows a first-pattern match when two patterns are configured.
- **ST_LOCKED** assembles characters at fixed boundaries.

Transitions:

- ST_HUNT → ST_LOCKED on a single-pattern match or on the external sync level.
- ST_HUNT → ST_SECOND on a first-pattern match in two-pattern mode.
- ST_SECOND → ST_LOCKED when the next character equals the second pattern.
- ST_SECOND → ST_HUNT when it does not.
- Any state → ST_HUNT on `enter_hunt`.

Completed characters go to an output register. They come with a ready flag, a sticky parity error flag and a sticky overrun flag. A sync-detect flag is shown on `sync_out`. `sync_oe` tells the pad whether that pin drives in internal mode or listens in external mode.

Top module: `sync_char_rx`

## Requirements
- R1: After reset, `rx_data` is 0, `rx_ready`, `par_err`, `ovr_err` and `sync_out` are 0, and the receiver is in ST_HUNT.
- R2: A data bit is taken on each rising edge of `rxc`. In ST_HUNT with internal sync and a single pattern, the flag rises once the last `5+cfg_len` received data bits equal `cfg_sync1` (first received bit compared with bit 0). The receiver then locks, and the next received bit is bit 0 of the first character.
- R3: With `cfg_single`=0, a first-pattern match gives no flag. The next full character is compared with `cfg_sync2`. On a match the flag rises and the receiver locks. On a mismatch it goes back to bit-by-bit hunting.
- R4: `enter_hunt` returns the receiver to ST_HUNT and fills the receive shift register with ones, so bits received before the command cannot complete a match.
- R5: The flag rises on the last data bit of the final sync character when `cfg_par_en`=0, and on the parity bit when `cfg_par_en`=1.
- R6: A `stat_rd` pulse clears the flag, and the receiver stays locked and keeps delivering characters.
- R7: While locked with internal sync, a sync pattern sets the flag only when it lies on a character boundary. A pattern that straddles two characters does not set it.
- R8: With `cfg_ext`=1, `sync_oe` is 0 and internal matching is off. A high on `sync_in` while hunting sets the flag and locks the receiver. The next rising edge of `rxc` gives bit 0 of the first character.
- R9: `rx_data` holds the data bits in its low `5+cfg_len` bits, first received bit in bit 0. The unused upper bits are 0, and the parity bit never appears.
- R10: When parity is on, a locked character whose data and parity bit have the wrong polarity sets `par_err`. `cfg_par_even`=1 selects even and 0 selects odd. This check runs whether or not `rx_en` is set. `par_err` stays set until `err_clr`.
- R11: When a character completes while `rx_ready` is 1, `ovr_err` is set and `rx_data` is overwritten with the new character. `ovr_err` stays set until `err_clr`.
- R12: `rx_ready` rises when a character completes with `rx_en`=1 and falls on `data_rd`. It stays 0 while `rx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxc | input | 1 | 1x receive bit clock, sampled on its rising edge |
| rxd | input | 1 | Serial receive data |
| sync_in | input | 1 | External sync-detect level (used when cfg_ext=1) |
| sync_out | output | 1 | Sync-detect flag |
| sync_oe | output | 1 | 1 when the sync pin should drive sync_out (internal mode) |
| cfg_len | input | 2 | Data length code, length = 5 + cfg_len |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_single | input | 1 | 1 = one sync pattern, 0 = two |
| cfg_ext | input | 1 | 1 = external sync source |
| cfg_sync1 | input | 8 | First sync pattern |
| cfg_sync2 | input | 8 | Second sync pattern |
| enter_hunt | input | 1 | One-cycle pulse: restart the hunt |
| rx_en | input | 1 | Receive enable for the ready flag |
| data_rd | input | 1 | One-cycle pulse: character taken |
| stat_rd | input | 1 | One-cycle pulse: status read, clears the sync flag |
| err_clr | input | 1 | One-cycle pulse: clears par_err and ovr_err |
| rx_data | output | 8 | Received character |
| rx_ready | output | 1 | Character waiting |
| par_err | output | 1 | Sticky parity error |
| ovr_err | output | 1 | Sticky overrun error |

## Verification
The assertions rest on these assumptions about the inputs:

- Each phase of `rxc` lasts longer than the synchronizer depth, so every rising edge gives exactly one bit event.
- `rxd` and `sync_in` are steady around that edge.
- The configuration inputs change only while the receiver is hunting, or together with an `enter_hunt`.
- Command inputs are single-cycle pulses.

The bench keeps to these assumptions. It holds each `rxc` phase for four system clocks and changes `rxd` only at the start of the low phase. It writes a new configuration just before an `enter_hunt` pulse. It spaces its pulses so that none of them falls on a bit event.

// File: rtl/sync_char_rx_pkg.sv
`timescale 1ns/1ps
package sync_char_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_SECOND = 2'd1,
        ST_LOCKED = 2'd2
    } rx_state_e;

endpackage

// File: rtl/scr_front.sv
`timescale 1ns/1ps
// Brings rxc, rxd and sync_in into the clk domain and flags rising rxc edges.
module scr_front #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxc,
    input  logic rxd,
    input  logic sync_in,
    output logic bit_tick,
    output logic bit_val,
    output logic ext_lvl
);
    logic [STAGES-1:0] c_pipe;
    logic [STAGES-1:0] d_pipe;
    logic [STAGES-1:0] e_pipe;
    logic              c_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_pipe <= '0;
            d_pipe <= '1;
            e_pipe <= '0;
            c_last <= 1'b0;
        end else begin
            c_pipe <= {c_pipe[STAGES-2:0], rxc};
            d_pipe <= {d_pipe[STAGES-2:0], rxd};
            e_pipe <= {e_pipe[STAGES-2:0], sync_in};
            c_last <= c_pipe[STAGES-1];
        end
    end

    assign bit_tick = c_pipe[STAGES-1] & ~c_last;
    assign bit_val  = d_pipe[STAGES-1];
    assign ext_lvl  = e_pipe[STAGES-1];

endmodule

// File: rtl/scr_shift.sv
`timescale 1ns/1ps
// Receive shift register. The newest bit enters at position 0, and the view
// {sr, bit} exposes the last frame of data bits plus an optional parity bit.
module scr_shift #(
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = 2,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              bit_val,
    input  logic              preset,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    output logic [DATA_W-1:0] win_data,
    output logic              win_par
);
    localparam int FR_W = DATA_W + 1;

    logic [FR_W-2:0] sr;
    logic [FR_W-1:0] view;
    int              dlen;
    int              flen;

    assign view = {sr, bit_val};

    always_comb begin
        dlen = MIN_LEN + int'(cfg_len);
        flen = dlen + int'(cfg_par_en);
    end

    // Data bit j, received j-th in the frame, sits at view position flen-1-j.
    always_comb begin
        win_data = '0;
        for (int j = 0; j < DATA_W; j++) begin
            for (int p = 0; p < FR_W; p++) begin
                if (j < dlen && p == flen - 1 - j) begin
                    win_data[j] = view[p];
                end
            end
        end
        win_par = view[0];
    end

    always_ff @(posedge clk) begin
        if (rst || preset) begin
            sr <= '1;
        end else if (bit_tick) begin
            sr <= view[FR_W-2:0];
        end
    end

endmodule

// File: rtl/scr_fsm.sv
`timescale 1ns/1ps
// Framing state machine: hunt, second-pattern check, locked assembly.
module scr_fsm
    import sync_char_rx_pkg::*;
#(
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = 2,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              ext_lvl,
    input  logic              enter_hunt,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_single,
    input  logic              cfg_ext,
    input  logic [DATA_W-1:0] cfg_sync1,
    input  logic [DATA_W-1:0] cfg_sync2,
    input  logic [DATA_W-1:0] win_data,
    output logic              frame_load,
    output logic              syn_set
);
    localparam int FR_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(FR_W + 1);

    rx_state_e          state, nxt_state;
    logic [CNT_W-1:0]   cnt, nxt_cnt;
    logic               pair1, nxt_pair1;
    logic [DATA_W-1:0]  len_mask;
    logic               hit1, hit2, last_bit;
    int                 flen;

    always_comb begin
        flen = MIN_LEN + int'(cfg_len) + int'(cfg_par_en);
        for (int j = 0; j < DATA_W; j++) begin
            len_mask[j] = (j < MIN_LEN + int'(cfg_len));
        end
        hit1     = (win_data == (cfg_sync1 & len_mask));
        hit2     = (win_data == (cfg_sync2 & len_mask));
        last_bit = (cnt == CNT_W'(flen - 1));
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HUNT;
            cnt   <= '0;
            pair1 <= 1'b0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            pair1 <= nxt_pair1;
        end
    end

    // Next state and outputs
    always_comb begin
        nxt_state  = state;
        nxt_cnt    = cnt;
        nxt_pair1  = pair1;
        frame_load = 1'b0;
        syn_set    = 1'b0;
        if (enter_hunt) begin
            nxt_state = ST_HUNT;
            nxt_cnt   = '0;
            nxt_pair1 = 1'b0;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    nxt_cnt = '0;
                    if (cfg_ext) begin
                        if (ext_lvl) begin
                            nxt_state = ST_LOCKED;
                            syn_set   = 1'b1;
                            nxt_pair1 = 1'b0;
                        end
                    end else if (bit_tick && hit1) begin
                        if (cfg_single) begin
                            nxt_state = ST_LOCKED;
                            syn_set   = 1'b1;
                        end else begin
                            nxt_state = ST_SECOND;
                        end
                        nxt_pair1 = 1'b0;
                    end
                end
                ST_SECOND: begin
                    if (bit_tick) begin
                        if (last_bit) begin
                            nxt_cnt = '0;
                            if (hit2) begin
                                nxt_state = ST_LOCKED;
                                syn_set   = 1'b1;
                            end else begin
                                nxt_state = ST_HUNT;
                            end
                        end else begin
                            nxt_cnt = cnt + CNT_W'(1);
                        end
                    end
                end
                ST_LOCKED: begin
                    if (bit_tick) begin
                        if (last_bit) begin
                            nxt_cnt    = '0;
                            frame_load = 1'b1;
                            if (!cfg_ext) begin
                                if (cfg_single) begin
                                    syn_set = hit1;
                                end else begin
                                    syn_set = pair1 && hit2;
                                end
                                nxt_pair1 = hit1;
                            end
                        end else begin
                            nxt_cnt = cnt + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    nxt_state = ST_HUNT;
                    nxt_cnt   = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/scr_out.sv
`timescale 1ns/1ps
// Output register, ready flag and sticky status flags.
module scr_out #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_load,
    input  logic              syn_set,
    input  logic [DATA_W-1:0] win_data,
    input  logic              win_par,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              rx_en,
    input  logic              data_rd,
    input  logic              stat_rd,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              par_err,
    output logic              ovr_err,
    output logic              syn_flag
);
    logic ones_odd;
    logic par_bad;

    always_comb begin
        ones_odd = ^{win_data, win_par};
        par_bad  = cfg_par_en && (cfg_par_even ? ones_odd : !ones_odd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
            par_err  <= 1'b0;
            ovr_err  <= 1'b0;
            syn_flag <= 1'b0;
        end else begin
            if (frame_load) begin
                rx_data <= win_data;
            end

            if (!rx_en) begin
                rx_ready <= 1'b0;
            end else if (frame_load) begin
                rx_ready <= 1'b1;
            end else if (data_rd) begin
                rx_ready <= 1'b0;
            end

            if (frame_load && rx_en && rx_ready) begin
                ovr_err <= 1'b1;
            end else if (err_clr) begin
                ovr_err <= 1'b0;
            end

            if (frame_load && par_bad) begin
                par_err <= 1'b1;
            end else if (err_clr) begin
                par_err <= 1'b0;
            end

            if (syn_set) begin
                syn_flag <= 1'b1;
            end else if (stat_rd) begin
                syn_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sync_char_rx.sv
`timescale 1ns/1ps
module sync_char_rx #(
    parameter  int MIN_LEN     = 5,
    parameter  int LEN_W       = 2,
    parameter  int SYNC_STAGES = 2,
    localparam int DATA_W      = MIN_LEN + (1 << LEN_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxc,
    input  logic              rxd,
    input  logic              sync_in,
    output logic              sync_out,
    output logic              sync_oe,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_single,
    input  logic              cfg_ext,
    input  logic [DATA_W-1:0] cfg_sync1,
    input  logic [DATA_W-1:0] cfg_sync2,
    input  logic              enter_hunt,
    input  logic              rx_en,
    input  logic              data_rd,
    input  logic              stat_rd,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              par_err,
    output logic              ovr_err
);
    logic              bit_tick;
    logic              bit_val;
    logic              ext_lvl;
    logic [DATA_W-1:0] win_data;
    logic              win_par;
    logic              frame_load;
    logic              syn_set;

    scr_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .rst      (rst),
        .rxc      (rxc),
        .rxd      (rxd),
        .sync_in  (sync_in),
        .bit_tick (bit_tick),
        .bit_val  (bit_val),
        .ext_lvl  (ext_lvl)
    );

    scr_shift #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .bit_val    (bit_val),
        .preset     (enter_hunt),
        .cfg_len    (cfg_len),
        .cfg_par_en (cfg_par_en),
        .win_data   (win_data),
        .win_par    (win_par)
    );

    scr_fsm #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .ext_lvl    (ext_lvl),
        .enter_hunt (enter_hunt),
        .cfg_len    (cfg_len),
        .cfg_par_en (cfg_par_en),
        .cfg_single (cfg_single),
        .cfg_ext    (cfg_ext),
        .cfg_sync1  (cfg_sync1),
        .cfg_sync2  (cfg_sync2),
        .win_data   (win_data),
        .frame_load (frame_load),
        .syn_set    (syn_set)
    );

    scr_out #(.DATA_W(DATA_W)) u_out (
        .clk          (clk),
        .rst          (rst),
        .frame_load   (frame_load),
        .syn_set      (syn_set),
        .win_data     (win_data),
        .win_par      (win_par),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .rx_en        (rx_en),
        .data_rd      (data_rd),
        .stat_rd      (stat_rd),
        .err_clr      (err_clr),
        .rx_data      (rx_data),
        .rx_ready     (rx_ready),
        .par_err      (par_err),
        .ovr_err      (ovr_err),
        .syn_flag     (sync_out)
    );

    assign sync_oe = ~cfg_ext;

endmodule

// File: rtl/sync_char_rx_chk.sv
`timescale 1ns/1ps
module sync_char_rx_chk #(
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = 2,
    parameter int DATA_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic              data_rd,
    input logic              stat_rd,
    input logic              err_clr,
    input logic              cfg_ext,
    input logic [LEN_W-1:0]  cfg_len,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_ready,
    input logic              par_err,
    input logic              ovr_err,
    input logic              sync_out,
    input logic              bit_tick,
    input logic              ext_lvl,
    input logic              frame_load,
    input logic              syn_set
);
    AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (rst) frame_load |-> bit_tick); // R2
    AST_SYN_CLEARED: assert property (@(posedge clk) disable iff (rst) (stat_rd && !syn_set) |=> !sync_out); // R6
    AST_EXT_SOURCE: assert property (@(posedge clk) disable iff (rst) (cfg_ext && $rose(sync_out)) |-> $past(ext_lvl)); // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) frame_load |=> ((rx_data >> (MIN_LEN + int'(cfg_len))) == '0)); // R9
    AST_PERR_HOLD: assert property (@(posedge clk) disable iff (rst) (par_err && !err_clr) |=> par_err); // R10
    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst) (frame_load && rx_ready && rx_en) |=> ovr_err); // R11
    AST_RDY_DISABLED: assert property (@(posedge clk) disable iff (rst) !rx_en |=> !rx_ready); // R12
    AST_RDY_READ: assert property (@(posedge clk) disable iff (rst) (data_rd && !frame_load) |=> !rx_ready); // R12
endmodule

bind sync_char_rx sync_char_rx_chk #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .data_rd    (data_rd),
    .stat_rd    (stat_rd),
    .err_clr    (err_clr),
    .cfg_ext    (cfg_ext),
    .cfg_len    (cfg_len),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .par_err    (par_err),
    .ovr_err    (ovr_err),
    .sync_out   (sync_out),
    .bit_tick   (bit_tick),
    .ext_lvl    (ext_lvl),
    .frame_load (frame_load),
    .syn_set    (syn_set)
);

// File: tb/sim_sync_char_rx.sv
`timescale 1ns/1ps
module sim_sync_char_rx;

    logic       clk = 1'b0;
    logic       rst;
    logic       rxc, rxd, sync_in;
    logic       sync_out, sync_oe;
    logic [1:0] cfg_len;
    logic       cfg_par_en, cfg_par_even, cfg_single, cfg_ext;
    logic [7:0] cfg_sync1, cfg_sync2;
    logic       enter_hunt, rx_en, data_rd, stat_rd, err_clr;
    logic [7:0] rx_data;
    logic       rx_ready, par_err, ovr_err;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    sync_char_rx u0 (
        .clk(clk), .rst(rst), .rxc(rxc), .rxd(rxd), .sync_in(sync_in),
        .sync_out(sync_out), .sync_oe(sync_oe), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_single(cfg_single), .cfg_ext(cfg_ext), .cfg_sync1(cfg_sync1),
        .cfg_sync2(cfg_sync2), .enter_hunt(enter_hunt), .rx_en(rx_en),
        .data_rd(data_rd), .stat_rd(stat_rd), .err_clr(err_clr),
        .rx_data(rx_data), .rx_ready(rx_ready), .par_err(par_err), .ovr_err(ovr_err)
    );

    function automatic logic [7:0] lmask(input int len);
        return 8'((1 << len) - 1);
    endfunction

    function automatic logic par_of(input logic [7:0] d, input int len, input logic even);
        logic x;
        x = ^(d & lmask(len));
        return even ? x : ~x;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rxd = b;
        rxc = 1'b0;
        repeat (4) @(negedge clk);
        rxc = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int len, input logic pe,
                              input logic even, input logic bad);
        for (int j = 0; j < len; j++) send_bit(d[j]);
        if (pe) send_bit(par_of(d, len, even) ^ bad);
    endtask

    task automatic do_hunt();
        @(negedge clk); enter_hunt = 1'b1; @(negedge clk); enter_hunt = 1'b0; @(negedge clk);
    endtask
    task automatic do_rd();
        @(negedge clk); data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
    endtask
    task automatic do_stat();
        @(negedge clk); stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
    endtask
    task automatic do_clr();
        @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    endtask

    task automatic set_cfg(input int len, input logic pe, input logic even,
                           input logic single, input logic ext,
                           input logic [7:0] s1, input logic [7:0] s2);
        @(negedge clk);
        cfg_len = 2'(len - 5); cfg_par_en = pe; cfg_par_even = even;
        cfg_single = single; cfg_ext = ext; cfg_sync1 = s1; cfg_sync2 = s2;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d, s1, s2;
        int         len, npre;
        logic       pe, even, single, bad;
        logic       e_rdy, e_perr, e_ovr;

        void'($urandom(32'd4711));
        rst = 1'b1; rxc = 1'b0; rxd = 1'b1; sync_in = 1'b0;
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_even = 1'b0; cfg_single = 1'b1;
        cfg_ext = 1'b0; cfg_sync1 = 8'h16; cfg_sync2 = 8'h68;
        enter_hunt = 1'b0; rx_en = 1'b1; data_rd = 1'b0; stat_rd = 1'b0; err_clr = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rx_data", 32'(rx_data), 0);
        chk("R1 rx_ready", 32'(rx_ready), 0);
        chk("R1 par_err", 32'(par_err), 0);
        chk("R1 ovr_err", 32'(ovr_err), 0);
        chk("R1 sync_out", 32'(sync_out), 0);
        chk("R1 sync_oe", 32'(sync_oe), 1);

        // R2 / R5: single pattern 0x16, 8 bits, no parity
        repeat (3) send_bit(1'b1);
        for (int j = 0; j < 7; j++) send_bit(d_bit(8'h16, j));
        chk("R5 no flag before last data bit", 32'(sync_out), 0);
        send_bit(1'b0);
        chk("R2 flag after single match", 32'(sync_out), 1);
        send_frame(8'hA5, 8, 0, 0, 0);
        chk("R9 first character", 32'(rx_data), 32'hA5);
        chk("R12 ready after character", 32'(rx_ready), 1);
        do_rd();
        chk("R12 ready cleared by read", 32'(rx_ready), 0);

        // R6 status read clears flag, stays locked
        do_stat();
        chk("R6 flag cleared", 32'(sync_out), 0);
        send_frame(8'h3C, 8, 0, 0, 0);
        chk("R6 still locked", 32'(rx_data), 32'h3C);
        do_rd();

        // R7 straddling pattern ignored, aligned pattern seen
        send_frame(8'h60, 8, 0, 0, 0);
        do_rd();
        send_frame(8'h01, 8, 0, 0, 0);
        do_rd();
        chk("R7 straddling pattern", 32'(sync_out), 0);
        send_frame(8'h16, 8, 0, 0, 0);
        chk("R7 aligned pattern", 32'(sync_out), 1);
        chk("R7 pattern delivered", 32'(rx_data), 32'h16);
        do_rd();

        // R11 overrun
        do_clr();
        send_frame(8'h11, 8, 0, 0, 0);
        chk("R11 no overrun yet", 32'(ovr_err), 0);
        send_frame(8'h22, 8, 0, 0, 0);
        chk("R11 overrun set", 32'(ovr_err), 1);
        chk("R11 data overwritten", 32'(rx_data), 32'h22);
        do_clr();
        chk("R11 overrun cleared", 32'(ovr_err), 0);
        do_rd();

        // R4 preset on enter hunt
        do_stat();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        do_hunt();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        chk("R4 stale bits do not match", 32'(sync_out), 0);
        send_frame(8'h16, 8, 0, 0, 0);
        chk("R4 hunt finds pattern", 32'(sync_out), 1);

        // R5 / R9 / R10 with 7 bits and even parity
        set_cfg(7, 1, 1, 1, 0, 8'h16, 8'h00);
        do_hunt(); do_stat(); do_rd(); do_clr();
        repeat (2) send_bit(1'b1);
        for (int j = 0; j < 7; j++) send_bit(d_bit(8'h16, j));
        chk("R5 no flag before parity bit", 32'(sync_out), 0);
        send_bit(par_of(8'h16, 7, 1));
        chk("R5 flag on parity bit", 32'(sync_out), 1);
        send_frame(8'h2A, 7, 1, 1, 0);
        chk("R9 parity bit hidden", 32'(rx_data), 32'h2A);
        chk("R10 good parity", 32'(par_err), 0);
        do_rd();
        send_frame(8'h55, 7, 1, 1, 1);
        chk("R10 bad parity", 32'(par_err), 1);
        do_rd();

        // R12 / R10 receive disabled
        @(negedge clk); rx_en = 1'b0;
        do_clr();
        send_frame(8'h33, 7, 1, 1, 1);
        chk("R12 ready held low", 32'(rx_ready), 0);
        chk("R10 parity checked while disabled", 32'(par_err), 1);
        @(negedge clk); rx_en = 1'b1;
        do_clr();

        // R3 double pattern with a mismatch first
        set_cfg(8, 0, 0, 0, 0, 8'h16, 8'h68);
        do_hunt(); do_stat(); do_rd();
        repeat (2) send_bit(1'b1);
        send_frame(8'h16, 8, 0, 0, 0);
        chk("R3 no flag after first pattern", 32'(sync_out), 0);
        send_frame(8'hFF, 8, 0, 0, 0);
        chk("R3 mismatch no flag", 32'(sync_out), 0);
        send_frame(8'h16, 8, 0, 0, 0);
        send_frame(8'h68, 8, 0, 0, 0);
        chk("R3 flag after both patterns", 32'(sync_out), 1);
        chk("R3 nothing delivered while hunting", 32'(rx_ready), 0);
        send_frame(8'h5A, 8, 0, 0, 0);
        chk("R3 locked data", 32'(rx_data), 32'h5A);
        do_rd();

        // R8 external sync
        set_cfg(8, 0, 0, 1, 1, 8'h16, 8'h00);
        do_hunt(); do_stat();
        chk("R8 pin not driven", 32'(sync_oe), 0);
        repeat (2) send_bit(1'b1);
        send_frame(8'h16, 8, 0, 0, 0);
        chk("R8 internal match disabled", 32'(sync_out), 0);
        chk("R8 nothing delivered", 32'(rx_ready), 0);
        @(negedge clk); sync_in = 1'b1;
        repeat (4) @(negedge clk);
        sync_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 flag from sync input", 32'(sync_out), 1);
        send_frame(8'hC3, 8, 0, 0, 0);
        chk("R8 first character after sync input", 32'(rx_data), 32'hC3);
        chk("R8 ready", 32'(rx_ready), 1);
        do_rd();

        // Random trials
        for (int t = 0; t < 30; t++) begin
            len    = 5 + int'($urandom % 4);
            pe     = 1'($urandom % 2);
            even   = 1'($urandom % 2);
            single = 1'($urandom % 2);
            s1     = 8'($urandom) & lmask(len) & 8'hFE;
            s2     = 8'($urandom) & lmask(len);
            set_cfg(len, pe, even, single, 0, s1, s2);
            do_hunt(); do_stat(); do_rd(); do_clr();
            e_rdy = 1'b0; e_perr = 1'b0; e_ovr = 1'b0;
            npre = int'($urandom % 4);
            for (int k = 0; k < npre; k++) send_bit(1'b1);
            send_frame(s1, len, pe, even, 0);
            if (!single) begin
                chk("R3 random first pattern no flag", 32'(sync_out), 0);
                send_frame(s2, len, pe, even, 0);
            end
            chk("R2 random lock flag", 32'(sync_out), 1);
            for (int c = 0; c < 3; c++) begin
                d   = 8'($urandom) & lmask(len);
                bad = pe && (($urandom % 4) == 0);
                send_frame(d, len, pe, even, bad);
                e_ovr  = e_ovr | e_rdy;
                e_rdy  = 1'b1;
                e_perr = e_perr | bad;
                chk("R9 random data", 32'(rx_data), 32'(d));
                chk("R12 random ready", 32'(rx_ready), 32'(e_rdy));
                chk("R10 random parity flag", 32'(par_err), 32'(e_perr));
                chk("R11 random overrun flag", 32'(ovr_err), 32'(e_ovr));
                if (($urandom % 3) != 0) begin
                    do_rd();
                    e_rdy = 1'b0;
                end
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

    function automatic logic d_bit(input logic [7:0] v, input int j);
        return v[j];
    endfunction

endmodule